// File: doc/BRIEF.md
# Status Register Write Protection Unit

This unit holds the 8-bit status byte of a serial memory and decides which writes are allowed. It has a write-enable latch, two block-protect bits that fence off the upper part of the array, and a status-lock bit. The status-lock bit works together with an external write-protect pin. The serial engine around the unit decodes the protocol. It passes the unit single-cycle strobes: chip select falling and rising, the enable and disable commands, and a status write with its data byte. In return the unit reports whether a status write was taken, the current status byte, and whether a given array address may be written.

A small state machine tracks the transaction. `SG_IDLE` moves to `SG_ACTIVE` on a chip-select-fall strobe, and at that moment it captures the write-protect pin. `SG_ACTIVE` returns to `SG_IDLE` on a chip-select-rise strobe. A power-restart strobe forces `SG_IDLE` from either state. Commands and status writes act only in `SG_ACTIVE`. The nonvolatile bits are ordinary registers that only the initial reset clears. A power restart clears only the latch.

Top module: `sreg_guard`

## Requirements
- R1: After `init_n` is asserted, `sr_rdata` reads 0x00 and `q_write_ok` is 0 for every address.
- R2: In `SG_ACTIVE`, `cmd_wren` sets bit 1 of the status byte (the latch) and `cmd_wrdi` clears it. When both arrive in the same cycle, the clear wins.
- R3: While the latch is 0, `q_write_ok` is 0 for every address and every status write is refused (`sr_accept` = 0).
- R4: With the latch at 1, the block-protect field is bits 3:2 of the status byte. Value 00 protects nothing. Value 01 protects addresses whose top two bits are 11. Value 10 protects addresses whose top bit is 1. Value 11 protects every address. `q_write_ok` is 1 exactly for the unprotected addresses.
- R5: With the latch at 1 and bit 7 (status lock) at 0, a status write in `SG_ACTIVE` is accepted whatever the write-protect level.
- R6: With the latch at 1 and bit 7 at 1, a status write is accepted only if `wp_pin` was high when the transaction's chip-select-fall strobe arrived. Changes of `wp_pin` later in the transaction have no effect.
- R7: An accepted status write loads bits 7:2 from `sr_wdata`. Bits 1:0 of the data are ignored, and bit 0 of the status byte always reads 0.
- R8: `pwr_restart` clears the latch and keeps bits 7:2.
- R9: An accepted status write does not clear the latch. Only `cmd_wrdi`, `pwr_restart` or `init_n` clear it.
- R10: Commands and status writes are ignored in `SG_IDLE`. This includes the state after `cs_rise` and the state forced by `pwr_restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| init_n | input | 1 | Asynchronous initial-state reset, active low, clears all bits |
| pwr_restart | input | 1 | Power-cycle strobe: clears latch, returns to idle |
| cs_fall | input | 1 | Transaction start strobe, samples `wp_pin` |
| cs_rise | input | 1 | Transaction end strobe |
| wp_pin | input | 1 | Write-protect pin level, high allows locked status writes |
| cmd_wren | input | 1 | Enable-latch set command strobe |
| cmd_wrdi | input | 1 | Enable-latch clear command strobe |
| sr_wr | input | 1 | Status write request strobe |
| sr_wdata | input | 8 | Status write data |
| q_addr | input | AW | Array address for the permission query |
| sr_rdata | output | 8 | Current status byte |
| q_write_ok | output | 1 | Address `q_addr` may be written |
| sr_accept | output | 1 | The status write presented this cycle is taken |

## Verification
Status writes are tried under all four combinations of lock bit and sampled pin. The pin is also flipped inside a transaction, which tells pin sampling apart from live pin use. Permission queries hit the addresses on both sides of the quarter and half boundaries for every block-protect value, so an off-by-one region decode shows up. Enable and disable commands are sent alone, together, and outside a transaction, which separates priority errors from state-gating errors. Written bytes carry ones in bits 1 and 0 and zeros where the latch sits, so any leak of those bits is visible.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;
    typedef enum logic {
        SG_IDLE   = 1'b0,
        SG_ACTIVE = 1'b1
    } sg_state_e;

    localparam int SR_W    = 8;
    localparam int LOCK_B  = 7;
    localparam int BPH_B   = 3;
    localparam int BPL_B   = 2;
    localparam int LATCH_B = 1;
    localparam int NV_LO   = 2;
    localparam int NV_W    = SR_W - NV_LO;
endpackage

// File: rtl/sreg_guard_ctrl.sv
module sreg_guard_ctrl
    import sreg_guard_pkg::*;
(
    input  logic clk,
    input  logic init_n,
    input  logic pwr_restart,
    input  logic cs_fall,
    input  logic cs_rise,
    input  logic wp_pin,
    input  logic cmd_wren,
    input  logic cmd_wrdi,
    input  logic sr_wr,
    input  logic wel,
    input  logic lock,
    output logic set_wel,
    output logic clr_wel,
    output logic sr_accept
);
    sg_state_e state, state_nx;
    logic      wp_held;
    logic      active;

    always_comb begin
        state_nx = state;
        unique case (state)
            SG_IDLE:   if (cs_fall) state_nx = SG_ACTIVE;
            SG_ACTIVE: if (cs_rise) state_nx = SG_IDLE;
            default:   state_nx = SG_IDLE;
        endcase
        if (pwr_restart) state_nx = SG_IDLE;
    end

    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) begin
            state   <= SG_IDLE;
            wp_held <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == SG_IDLE && cs_fall && !pwr_restart)
                wp_held <= wp_pin;
        end
    end

    always_comb begin
        active    = (state == SG_ACTIVE) && !pwr_restart;
        set_wel   = active && cmd_wren && !cmd_wrdi;
        clr_wel   = active && cmd_wrdi;
        sr_accept = active && sr_wr && wel && (!lock || wp_held);
    end

    // R10
    end_idle_chk: assert property (@(posedge clk) disable iff (!init_n)
        (state == SG_ACTIVE && cs_rise) |=> (state == SG_IDLE));

    // R10
    restart_idle_chk: assert property (@(posedge clk) disable iff (!init_n)
        pwr_restart |=> (state == SG_IDLE));

    // R6
    held_pin_chk: assert property (@(posedge clk) disable iff (!init_n)
        (state == SG_ACTIVE) |=> $stable(wp_held));
endmodule

// File: rtl/sreg_guard_regs.sv
module sreg_guard_regs
    import sreg_guard_pkg::*;
(
    input  logic            clk,
    input  logic            init_n,
    input  logic            pwr_restart,
    input  logic            set_wel,
    input  logic            clr_wel,
    input  logic            sr_load,
    input  logic [SR_W-1:0] sr_wdata,
    output logic [SR_W-1:0] sr_q
);
    logic [NV_W-1:0] nv_bits;
    logic            wel;

    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) begin
            nv_bits <= '0;
            wel     <= 1'b0;
        end else begin
            if (pwr_restart)  wel <= 1'b0;
            else if (clr_wel) wel <= 1'b0;
            else if (set_wel) wel <= 1'b1;
            if (sr_load) nv_bits <= sr_wdata[SR_W-1:NV_LO];
        end
    end

    assign sr_q = {nv_bits, wel, 1'b0};

    // R3
    load_needs_latch_chk: assert property (@(posedge clk) disable iff (!init_n)
        sr_load |-> wel);

    // R7
    load_value_chk: assert property (@(posedge clk) disable iff (!init_n)
        sr_load |=> (sr_q[SR_W-1:NV_LO] == $past(sr_wdata[SR_W-1:NV_LO])));

    // R7
    low_ignored_chk: assert property (@(posedge clk) disable iff (!init_n)
        (sr_load && !set_wel && !clr_wel && !pwr_restart && (sr_wdata[1:0] != 2'b00))
        |=> (sr_q[1:0] == {$past(sr_q[LATCH_B]), 1'b0}));

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!init_n)
        (sr_q[LATCH_B] && !clr_wel && !pwr_restart) |=> sr_q[LATCH_B]);

    // R8
    restart_keep_chk: assert property (@(posedge clk) disable iff (!init_n)
        pwr_restart |=> (!sr_q[LATCH_B] && $stable(sr_q[SR_W-1:NV_LO])));
endmodule

// File: rtl/sreg_guard_region.sv
module sreg_guard_region #(
    parameter int AW = 15
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    bp,
    output logic          prot
);
    logic top_half;
    logic top_quarter;

    generate
        if (AW >= 2) begin : g_wide
            assign top_half    = addr[AW-1];
            assign top_quarter = &addr[AW-1:AW-2];
        end else begin : g_narrow
            assign top_half    = addr[AW-1];
            assign top_quarter = addr[AW-1];
        end
    endgenerate

    always_comb begin
        unique case (bp)
            2'b00:   prot = 1'b0;
            2'b01:   prot = top_quarter;
            2'b10:   prot = top_half;
            default: prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
    import sreg_guard_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic            clk,
    input  logic            init_n,
    input  logic            pwr_restart,
    input  logic            cs_fall,
    input  logic            cs_rise,
    input  logic            wp_pin,
    input  logic            cmd_wren,
    input  logic            cmd_wrdi,
    input  logic            sr_wr,
    input  logic [SR_W-1:0] sr_wdata,
    input  logic [AW-1:0]   q_addr,
    output logic [SR_W-1:0] sr_rdata,
    output logic            q_write_ok,
    output logic            sr_accept
);
    logic            set_wel, clr_wel, prot;
    logic [SR_W-1:0] sr_q;

    sreg_guard_ctrl u_ctrl (
        .clk         (clk),
        .init_n      (init_n),
        .pwr_restart (pwr_restart),
        .cs_fall     (cs_fall),
        .cs_rise     (cs_rise),
        .wp_pin      (wp_pin),
        .cmd_wren    (cmd_wren),
        .cmd_wrdi    (cmd_wrdi),
        .sr_wr       (sr_wr),
        .wel         (sr_q[LATCH_B]),
        .lock        (sr_q[LOCK_B]),
        .set_wel     (set_wel),
        .clr_wel     (clr_wel),
        .sr_accept   (sr_accept)
    );

    sreg_guard_regs u_regs (
        .clk         (clk),
        .init_n      (init_n),
        .pwr_restart (pwr_restart),
        .set_wel     (set_wel),
        .clr_wel     (clr_wel),
        .sr_load     (sr_accept),
        .sr_wdata    (sr_wdata),
        .sr_q        (sr_q)
    );

    sreg_guard_region #(.AW(AW)) u_region (
        .addr (q_addr),
        .bp   (sr_q[BPH_B:BPL_B]),
        .prot (prot)
    );

    assign sr_rdata   = sr_q;
    assign q_write_ok = sr_q[LATCH_B] && !prot;

    // R4
    all_lock_chk: assert property (@(posedge clk) disable iff (!init_n)
        (sr_rdata[BPH_B:BPL_B] == 2'b11) |-> !q_write_ok);

    // R3
    latch_off_chk: assert property (@(posedge clk) disable iff (!init_n)
        !sr_rdata[LATCH_B] |-> (!q_write_ok && !sr_accept));
endmodule

// File: tb/sreg_guard_bench.sv
`timescale 1ns/1ps
module sreg_guard_bench;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          init_n = 1'b0;
    logic          pwr_restart = 1'b0, cs_fall = 1'b0, cs_rise = 1'b0, wp_pin = 1'b0;
    logic          cmd_wren = 1'b0, cmd_wrdi = 1'b0, sr_wr = 1'b0;
    logic [7:0]    sr_wdata = 8'h00;
    logic [AW-1:0] q_addr = '0;
    logic [7:0]    sr_rdata;
    logic          q_write_ok, sr_accept;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    sreg_guard #(.AW(AW)) u_sreg_guard (
        .clk(clk), .init_n(init_n), .pwr_restart(pwr_restart),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .wp_pin(wp_pin),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .sr_wr(sr_wr),
        .sr_wdata(sr_wdata), .q_addr(q_addr), .sr_rdata(sr_rdata),
        .q_write_ok(q_write_ok), .sr_accept(sr_accept)
    );

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.sel)
                    0:       act = sr_rdata;
                    1:       act = {7'd0, q_write_ok};
                    default: act = {7'd0, sr_accept};
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic exp_rd(input logic [7:0] e, input string tag);
        sb_q.push_back('{0, e, tag});
    endtask

    task automatic exp_ok(input logic [AW-1:0] a, input logic e, input string tag);
        q_addr = a;
        sb_q.push_back('{1, {7'd0, e}, tag});
        tick();
    endtask

    task automatic begin_txn(input logic wp);
        wp_pin = wp; cs_fall = 1'b1; tick(); cs_fall = 1'b0;
    endtask

    task automatic end_txn();
        cs_rise = 1'b1; tick(); cs_rise = 1'b0;
    endtask

    task automatic cmd(input logic en, input logic dis);
        cmd_wren = en; cmd_wrdi = dis; tick(); cmd_wren = 1'b0; cmd_wrdi = 1'b0;
    endtask

    task automatic srwr(input logic [7:0] d, input logic acc, input string tag);
        sr_wr = 1'b1; sr_wdata = d;
        sb_q.push_back('{2, {7'd0, acc}, tag});
        tick();
        sr_wr = 1'b0; sr_wdata = 8'h00;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        init_n = 1'b1;
        tick();
        // R1 reset state
        exp_rd(8'h00, "R1 reset byte");
        exp_ok(15'h0000, 1'b0, "R1 reset query low");
        exp_ok(15'h7FFF, 1'b0, "R1 reset query high");
        // R10 command outside transaction ignored
        cmd(1'b1, 1'b0);
        exp_rd(8'h00, "R10 wren in idle");
        // R2 set then clear
        begin_txn(1'b1); cmd(1'b1, 1'b0); end_txn();
        exp_rd(8'h02, "R2 wren sets latch");
        begin_txn(1'b1); cmd(1'b0, 1'b1); end_txn();
        exp_rd(8'h00, "R2 wrdi clears latch");
        begin_txn(1'b1); cmd(1'b1, 1'b0); end_txn();
        exp_rd(8'h02, "R2 wren again");
        // R4 bp 00
        exp_ok(15'h0000, 1'b1, "R4 bp00 low");
        exp_ok(15'h7FFF, 1'b1, "R4 bp00 top");
        // R5 unlocked write with pin low, R7 low bits ignored, R9 latch kept
        begin_txn(1'b0);
        srwr(8'h07, 1'b1, "R5 unlocked pin low");
        exp_rd(8'h06, "R7 R9 byte after 0x07");
        exp_ok(15'h5FFF, 1'b1, "R4 bp01 below quarter");
        exp_ok(15'h6000, 1'b0, "R4 bp01 quarter start");
        exp_ok(15'h7FFF, 1'b0, "R4 bp01 top");
        srwr(8'h08, 1'b1, "R5 write bp10");
        exp_rd(8'h0A, "R7 byte bp10");
        exp_ok(15'h3FFF, 1'b1, "R4 bp10 below half");
        exp_ok(15'h4000, 1'b0, "R4 bp10 half start");
        srwr(8'h0C, 1'b1, "R5 write bp11");
        exp_ok(15'h0000, 1'b0, "R4 bp11 low");
        srwr(8'hF0, 1'b1, "R5 write lock");
        exp_rd(8'hF2, "R7 R9 latch kept with zero data bit");
        exp_ok(15'h7FFF, 1'b1, "R4 bp00 after lock");
        end_txn();
        // R6 pin low at start, raised later
        begin_txn(1'b0); wp_pin = 1'b1;
        srwr(8'h04, 1'b0, "R6 locked pin sampled low");
        end_txn();
        exp_rd(8'hF2, "R6 byte unchanged");
        // R6 pin high at start, dropped later
        begin_txn(1'b1); wp_pin = 1'b0;
        srwr(8'h84, 1'b1, "R6 locked pin sampled high");
        end_txn();
        exp_rd(8'h86, "R6 byte loaded");
        // R2 both commands, clear wins
        begin_txn(1'b1); cmd(1'b1, 1'b1); end_txn();
        exp_rd(8'h84, "R2 wrdi wins");
        exp_ok(15'h0000, 1'b0, "R3 query with latch off");
        begin_txn(1'b1);
        srwr(8'h00, 1'b0, "R3 write refused latch off");
        end_txn();
        exp_rd(8'h84, "R3 byte unchanged");
        // R8 power restart
        begin_txn(1'b1); cmd(1'b1, 1'b0); end_txn();
        exp_rd(8'h86, "R8 latch before restart");
        pwr_restart = 1'b1; tick(); pwr_restart = 1'b0;
        exp_rd(8'h84, "R8 only latch cleared");
        // R10 restart inside transaction forces idle
        begin_txn(1'b1);
        pwr_restart = 1'b1; tick(); pwr_restart = 1'b0;
        cmd(1'b1, 1'b0);
        exp_rd(8'h84, "R10 wren after restart ignored");
        cs_rise = 1'b1; tick(); cs_rise = 1'b0;
        // R10 status write in idle ignored
        begin_txn(1'b1); cmd(1'b1, 1'b0); end_txn();
        srwr(8'h00, 1'b0, "R10 write in idle refused");
        exp_rd(8'h86, "R10 byte unchanged");
        tick(); tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule